// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block works out which processor agents should receive an interrupt message. It holds a per-agent configuration table with these fields for each of up to 256 agents:

- a presence flag;
- an 8-bit agent ID;
- an 8-bit logical destination;
- a 4-bit logical model.

Software-side logic fills the table through a single-entry write port. A request supplies the two command words of an inter-processor message, the index of the sending agent and a lowest-priority flag. The block answers with a 256-bit delivery mask, one bit per agent, and raises `done` when the mask is ready.

A two-bit shorthand field can override the destination: it selects the sender alone, every agent, or every agent but the sender. When the shorthand is zero, the destination byte is interpreted in one of two ways:

- **Physical mode:** the destination is an agent ID. The value 0xFF broadcasts to all agents. Any other value is resolved by a sequential search, one table entry per clock, for the lowest-numbered present agent carrying that ID.
- **Logical mode:** each agent decides for itself, according to its own model field, whether it is addressed. In the flat model the destination is a bit set. In the cluster model the upper nibble names a cluster and the lower nibble is a member set.

For lowest-priority delivery the finished mask is cut down to its lowest-numbered set bit.

Top module: `irq_dest_mask_gen`

## Requirements
- R1: After reset `done` is low, `mask` is all zero, and every table entry is marked not present.
- R2: With shorthand 2, the mask selects every present agent, including the sender.
- R3: With shorthand 3, the mask selects every present agent except the sender (`req_self`).
- R4: With shorthand 1, the mask selects only the sender, and is empty when the sender is not present.
- R5: With shorthand 0 in physical mode, destination 0xFF selects every present agent, and `done` rises one cycle after the request is accepted.
- R6: With shorthand 0 in physical mode and any destination other than 0xFF, the mask holds only the lowest-numbered present agent whose ID equals the destination. If that agent has index k, `done` rises k+1 cycles after acceptance. If no agent matches, the mask is empty and `done` rises N_AGENTS cycles after acceptance.
- R7: In logical mode, an agent whose model field is 0xF is selected when its logical destination ANDed with the destination byte is non-zero.
- R8: In logical mode, an agent whose model field is 0x0 is selected only when both of these hold: the upper nibbles of its logical destination and of the destination byte are equal, and the AND of their lower nibbles is non-zero.
- R9: In logical mode, an agent whose model field is neither 0x0 nor 0xF is never selected.
- R10: An agent marked not present is never selected, whatever the shorthand or mode.
- R11: When `req_lowpri` is set, the mask keeps only its lowest-numbered set bit, or stays empty.
- R12: A request is accepted when `req_valid` is high and no request is in flight. On the next cycle `done` is low. While `done` is low, `mask` reads all zero. All requests other than the physical search of R6 complete one cycle after acceptance.
- R13: The command fields sit at fixed positions: shorthand in `cmd_lo[19:18]`, mode in `cmd_lo[11]` (1 = logical), and destination in `cmd_hi[31:24]`. All other command bits have no effect on the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Agent entry to write |
| cfg_id | input | 8 | Agent ID written to the entry |
| cfg_ldest | input | 8 | Logical destination written to the entry |
| cfg_model | input | 4 | Logical model written to the entry (0xF flat, 0x0 cluster) |
| cfg_present | input | 1 | Presence flag written to the entry |
| req_valid | input | 1 | Request strobe |
| req_lowpri | input | 1 | Reduce the result to one agent |
| req_self | input | IDX_W | Index of the sending agent |
| cmd_lo | input | 32 | Low command word (shorthand, mode) |
| cmd_hi | input | 32 | High command word (destination) |
| done | output | 1 | Mask valid |
| mask | output | N_AGENTS | Delivery mask, bit i for agent i |

## Verification
The bench targets the following corner cases. For each, it is stated what a wrong design would do.

- **Duplicate IDs:** two agents share an ID. A search that kept the last hit instead of the first would name the higher agent.
- **Absent sender:** the sending agent is not present. A design that skipped the presence filter on the shorthand paths would still select it.
- **Missed search:** no agent holds the destination ID. A design that stopped the search early would report `done` too soon and give a different latency.
- **Mixed models in logical mode:** flat, cluster and undefined models sit side by side. A design that applied one rule to all agents, or let an undefined model fall into the flat rule, would show extra bits. Cluster destinations whose upper nibble differs by one bit are also sent, which exposes a nibble compare that was dropped.
- **Stray command bits:** every command bit outside the three fields is randomized. A decoder that read the wrong bit positions would change the result.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

   localparam int AGENT_ID_W = 8;
   localparam int NIB_W      = AGENT_ID_W / 2;
   localparam int MODEL_W    = 4;

   localparam logic [MODEL_W-1:0]    MODEL_FLAT    = 4'hF;
   localparam logic [MODEL_W-1:0]    MODEL_CLUSTER = 4'h0;
   localparam logic [AGENT_ID_W-1:0] BCAST_DEST    = 8'hFF;

   // command word field positions
   localparam int SH_LSB    = 18;
   localparam int MODE_BIT  = 11;
   localparam int DEST_LSB  = 24;

   typedef enum logic [1:0] {
      SH_DEST   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

endpackage

// File: rtl/irq_dest_table.sv
module irq_dest_table
   import irq_dest_pkg::*;
#(
   parameter int N_AGENTS = 256,
   localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [IDX_W-1:0]                      wr_idx,
   input  logic [AGENT_ID_W-1:0]                 wr_id,
   input  logic [AGENT_ID_W-1:0]                 wr_ldest,
   input  logic [MODEL_W-1:0]                    wr_model,
   input  logic                                  wr_present,
   output logic [N_AGENTS-1:0][AGENT_ID_W-1:0]   id_vec,
   output logic [N_AGENTS-1:0][AGENT_ID_W-1:0]   ldest_vec,
   output logic [N_AGENTS-1:0][MODEL_W-1:0]      model_vec,
   output logic [N_AGENTS-1:0]                   present_vec
);

   logic idx_in_range;
   assign idx_in_range = (int'(wr_idx) < N_AGENTS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_vec      <= '0;
         ldest_vec   <= '0;
         model_vec   <= '0;
         present_vec <= '0;
      end else if (wr_en && idx_in_range) begin
         id_vec[wr_idx]      <= wr_id;
         ldest_vec[wr_idx]   <= wr_ldest;
         model_vec[wr_idx]   <= wr_model;
         present_vec[wr_idx] <= wr_present;
      end
   end

endmodule

// File: rtl/irq_dest_logical_match.sv
module irq_dest_logical_match
   import irq_dest_pkg::*;
#(
   parameter int N_AGENTS = 256
) (
   input  logic [AGENT_ID_W-1:0]                 dest,
   input  logic [N_AGENTS-1:0][AGENT_ID_W-1:0]   ldest_vec,
   input  logic [N_AGENTS-1:0][MODEL_W-1:0]      model_vec,
   output logic [N_AGENTS-1:0]                   hit
);

   for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
      logic flat_ok;
      logic cluster_ok;
      logic is_flat;
      logic is_cluster;

      assign is_flat    = (model_vec[g] == MODEL_FLAT);
      assign is_cluster = (model_vec[g] == MODEL_CLUSTER);
      assign flat_ok    = |(ldest_vec[g] & dest);
      assign cluster_ok = (ldest_vec[g][AGENT_ID_W-1:NIB_W] == dest[AGENT_ID_W-1:NIB_W])
                       && |(ldest_vec[g][NIB_W-1:0] & dest[NIB_W-1:0]);
      assign hit[g]     = (is_flat && flat_ok) || (is_cluster && cluster_ok);
   end

endmodule

// File: rtl/irq_dest_lowest_pick.sv
module irq_dest_lowest_pick #(
   parameter int N_AGENTS = 256
) (
   input  logic [N_AGENTS-1:0] vec_i,
   output logic [N_AGENTS-1:0] vec_o
);

   // two's complement isolates the least significant set bit
   logic [N_AGENTS-1:0] neg_vec;
   assign neg_vec = ~vec_i + {{(N_AGENTS-1){1'b0}}, 1'b1};
   assign vec_o   = vec_i & neg_vec;

endmodule

// File: rtl/irq_dest_mask_gen.sv
module irq_dest_mask_gen
   import irq_dest_pkg::*;
#(
   parameter int N_AGENTS = 256,
   localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [IDX_W-1:0]          cfg_idx,
   input  logic [AGENT_ID_W-1:0]     cfg_id,
   input  logic [AGENT_ID_W-1:0]     cfg_ldest,
   input  logic [MODEL_W-1:0]        cfg_model,
   input  logic                      cfg_present,
   input  logic                      req_valid,
   input  logic                      req_lowpri,
   input  logic [IDX_W-1:0]          req_self,
   input  logic [31:0]               cmd_lo,
   input  logic [31:0]               cmd_hi,
   output logic                      done,
   output logic [N_AGENTS-1:0]       mask
);

   localparam logic [IDX_W-1:0]    LAST_IDX = IDX_W'(N_AGENTS - 1);
   localparam logic [N_AGENTS-1:0] ONE_HOT0 = {{(N_AGENTS-1){1'b0}}, 1'b1};

   if (N_AGENTS < 2 || N_AGENTS > 256) begin : g_bad_agents
      $error("irq_dest_mask_gen: N_AGENTS must lie in 2..256");
   end

   // configuration table
   logic [N_AGENTS-1:0][AGENT_ID_W-1:0] id_vec;
   logic [N_AGENTS-1:0][AGENT_ID_W-1:0] ldest_vec;
   logic [N_AGENTS-1:0][MODEL_W-1:0]    model_vec;
   logic [N_AGENTS-1:0]                 present_vec;

   irq_dest_table #(.N_AGENTS(N_AGENTS)) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (cfg_we),
      .wr_idx      (cfg_idx),
      .wr_id       (cfg_id),
      .wr_ldest    (cfg_ldest),
      .wr_model    (cfg_model),
      .wr_present  (cfg_present),
      .id_vec      (id_vec),
      .ldest_vec   (ldest_vec),
      .model_vec   (model_vec),
      .present_vec (present_vec)
   );

   // request state
   logic                  busy_q;
   logic                  done_q;
   logic                  logical_q;
   logic                  lowpri_q;
   shorthand_e            sh_q;
   logic [AGENT_ID_W-1:0] dest_q;
   logic [IDX_W-1:0]      self_q;
   logic [IDX_W-1:0]      scan_idx_q;
   logic [N_AGENTS-1:0]   mask_q;

   logic accept;
   assign accept = req_valid && !busy_q;

   // only the command fields are decoded; the reduction keeps the rest visibly consumed
   logic unused_cmd_bits;
   assign unused_cmd_bits = ^{cmd_lo, cmd_hi};

   // logical match across all agents
   logic [N_AGENTS-1:0] logic_hit;

   irq_dest_logical_match #(.N_AGENTS(N_AGENTS)) u_logic (
      .dest      (dest_q),
      .ldest_vec (ldest_vec),
      .model_vec (model_vec),
      .hit       (logic_hit)
   );

   // direct selection for shorthand, broadcast and logical paths
   logic [N_AGENTS-1:0] self_onehot;
   logic [N_AGENTS-1:0] direct_sel;
   logic                need_scan;
   logic                scan_hit;
   logic                finish;
   logic [N_AGENTS-1:0] cand;
   logic [N_AGENTS-1:0] picked;
   logic [N_AGENTS-1:0] final_mask;

   assign self_onehot = ONE_HOT0 << self_q;
   assign need_scan   = (sh_q == SH_DEST) && !logical_q && (dest_q != BCAST_DEST);

   always_comb begin
      unique case (sh_q)
         SH_SELF:   direct_sel = self_onehot;
         SH_ALL:    direct_sel = '1;
         SH_OTHERS: direct_sel = ~self_onehot;
         default:   begin
            if (logical_q)                 direct_sel = logic_hit;
            else if (dest_q == BCAST_DEST) direct_sel = '1;
            else                           direct_sel = '0;
         end
      endcase
   end

   // physical search, one entry per cycle
   assign scan_hit = present_vec[scan_idx_q] && (id_vec[scan_idx_q] == dest_q);
   assign finish   = busy_q && (!need_scan || scan_hit || (scan_idx_q == LAST_IDX));

   always_comb begin
      if (need_scan) cand = scan_hit ? (ONE_HOT0 << scan_idx_q) : '0;
      else           cand = direct_sel & present_vec;
   end

   irq_dest_lowest_pick #(.N_AGENTS(N_AGENTS)) u_pick (
      .vec_i (cand),
      .vec_o (picked)
   );

   assign final_mask = lowpri_q ? picked : cand;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         logical_q  <= 1'b0;
         lowpri_q   <= 1'b0;
         sh_q       <= SH_DEST;
         dest_q     <= '0;
         self_q     <= '0;
         scan_idx_q <= '0;
         mask_q     <= '0;
      end else if (accept) begin
         busy_q     <= 1'b1;
         done_q     <= 1'b0;
         mask_q     <= '0;
         logical_q  <= cmd_lo[MODE_BIT];
         lowpri_q   <= req_lowpri;
         sh_q       <= shorthand_e'(cmd_lo[SH_LSB +: 2]);
         dest_q     <= cmd_hi[DEST_LSB +: AGENT_ID_W];
         self_q     <= req_self;
         scan_idx_q <= '0;
      end else if (finish) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b1;
         mask_q     <= final_mask;
      end else if (busy_q) begin
         scan_idx_q <= scan_idx_q + 1'b1;
      end
   end

   assign done = done_q;
   assign mask = mask_q;

endmodule

// File: rtl/irq_dest_mask_gen_chk.sv
module irq_dest_mask_gen_chk #(
   parameter int N_AGENTS = 256,
   localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                done,
   input logic [N_AGENTS-1:0] mask,
   input logic [N_AGENTS-1:0] present_vec,
   input logic                accept,
   input logic                lowpri_q,
   input logic [1:0]          sh_q,
   input logic [IDX_W-1:0]    self_q
);

   logic [N_AGENTS-1:0] self_bit;
   assign self_bit = {{(N_AGENTS-1){1'b0}}, 1'b1} << self_q;

   // R12: no mask is shown while the result is pending
   a_r12_quiet_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (mask == '0));

   // R12: acceptance withdraws done on the next cycle
   a_r12_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !done);

   // R10: a fresh result never names an absent agent
   a_r10_present_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ((mask & ~present_vec) == '0));

   // R11: lowest-priority results hold at most one agent
   a_r11_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lowpri_q) |-> ($countones(mask) <= 1));

   // R4: self shorthand never reaches another agent
   a_r4_self_only: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sh_q == 2'd1) |-> ((mask & ~self_bit) == '0));

   // R3: all-but-self shorthand leaves the sender out
   a_r3_sender_excluded: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sh_q == 2'd3) |-> ((mask & self_bit) == '0));

endmodule

bind irq_dest_mask_gen irq_dest_mask_gen_chk #(.N_AGENTS(N_AGENTS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .done        (done),
   .mask        (mask),
   .present_vec (present_vec),
   .accept      (accept),
   .lowpri_q    (lowpri_q),
   .sh_q        (sh_q),
   .self_q      (self_q)
);

// File: tb/irq_dest_mask_gen_tb_top.sv
`timescale 1ns/1ps
module irq_dest_mask_gen_tb_top;

   localparam int N     = 256;
   localparam int IDX_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [IDX_W-1:0] cfg_idx = '0;
   logic [7:0]       cfg_id = '0;
   logic [7:0]       cfg_ldest = '0;
   logic [3:0]       cfg_model = '0;
   logic             cfg_present = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_lowpri = 1'b0;
   logic [IDX_W-1:0] req_self = '0;
   logic [31:0]      cmd_lo = '0;
   logic [31:0]      cmd_hi = '0;
   logic             done;
   logic [N-1:0]     mask;

   always #4 clk = ~clk;

   irq_dest_mask_gen #(.N_AGENTS(N)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_id(cfg_id), .cfg_ldest(cfg_ldest),
      .cfg_model(cfg_model), .cfg_present(cfg_present),
      .req_valid(req_valid), .req_lowpri(req_lowpri), .req_self(req_self),
      .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .done(done), .mask(mask)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench copy of the table, kept from the bench's own writes
   logic [7:0] b_id    [N];
   logic [7:0] b_ld    [N];
   logic [3:0] b_model [N];
   bit         b_pres  [N];

   function automatic logic [N-1:0] ref_mask(logic [7:0] dest, bit logical, int sh, int self_i, bit lowpri);
      logic [N-1:0] m = '0;
      bit s;
      if (sh == 0 && !logical && dest != 8'hFF) begin
         for (int i = 0; i < N; i++) begin
            if (b_pres[i] && b_id[i] == dest) begin
               m[i] = 1'b1;
               break;
            end
         end
      end else begin
         for (int i = 0; i < N; i++) begin
            s = 1'b0;
            case (sh)
               1: s = (i == self_i);
               2: s = 1'b1;
               3: s = (i != self_i);
               default: begin
                  if (!logical) s = 1'b1;
                  else if (b_model[i] == 4'hF) s = ((b_ld[i] & dest) != 0);
                  else if (b_model[i] == 4'h0)
                     s = (b_ld[i][7:4] == dest[7:4]) && ((b_ld[i][3:0] & dest[3:0]) != 0);
               end
            endcase
            m[i] = s && b_pres[i];
         end
      end
      if (lowpri) begin
         for (int i = 0; i < N; i++) begin
            if (m[i]) begin
               m = '0;
               m[i] = 1'b1;
               break;
            end
         end
      end
      return m;
   endfunction

   function automatic int ref_lat(logic [7:0] dest, bit logical, int sh);
      if (sh == 0 && !logical && dest != 8'hFF) begin
         for (int i = 0; i < N; i++)
            if (b_pres[i] && b_id[i] == dest) return i + 1;
         return N;
      end
      return 1;
   endfunction

   task automatic chk_mask(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s mask actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_int(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(int idx, logic [7:0] id, logic [7:0] ld, logic [3:0] model, bit pres);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_id = id; cfg_ldest = ld;
      cfg_model = model; cfg_present = pres;
      @(negedge clk);
      cfg_we = 1'b0;
      b_id[idx] = id; b_ld[idx] = ld; b_model[idx] = model; b_pres[idx] = pres;
   endtask

   task automatic run_req(string tag, logic [7:0] dest, bit logical, int sh, int self_i,
                          bit lowpri, logic [31:0] lo_fill, logic [31:0] hi_fill);
      int lat;
      logic [N-1:0] exp_m;
      exp_m = ref_mask(dest, logical, sh, self_i, lowpri);
      @(negedge clk);
      cmd_lo = lo_fill;
      cmd_lo[19:18] = 2'(sh);
      cmd_lo[11] = logical;
      cmd_hi = hi_fill;
      cmd_hi[31:24] = dest;
      req_self = IDX_W'(self_i);
      req_lowpri = lowpri;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cmd_lo = $urandom; cmd_hi = $urandom; req_lowpri = $urandom; req_self = $urandom;
      // R12: pending result is hidden
      chk_int({tag, " R12 done low after accept"}, int'(done), 0);
      chk_mask({tag, " R12 mask quiet"}, mask, '0);
      lat = 0;
      while (!done && lat < N + 4) begin
         @(negedge clk);
         lat++;
      end
      chk_int({tag, " latency R6 R12"}, lat, ref_lat(dest, logical, sh));
      chk_mask(tag, mask, exp_m);
   endtask

   initial begin
      logic [7:0] d;
      int sh;
      bit lg;
      void'($urandom(32'd2718));
      for (int i = 0; i < N; i++) begin
         b_id[i] = '0; b_ld[i] = '0; b_model[i] = '0; b_pres[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk_int("R1 done after reset", int'(done), 0);
      chk_mask("R1 mask after reset", mask, '0);
      run_req("R1 empty table broadcast", 8'hFF, 1'b0, 2, 0, 1'b0, 32'h0, 32'h0);

      // directed table: unique IDs, flat model, one-hot logical destinations
      for (int i = 0; i < N; i++) wr(i, 8'(i), 8'(1 << (i % 8)), 4'hF, 1'b1);
      wr(9, 8'd9, 8'h02, 4'hF, 1'b0);
      wr(5, 8'd7, 8'h20, 4'hF, 1'b1);
      wr(20, 8'd20, 8'h52, 4'h0, 1'b1);
      wr(21, 8'd21, 8'hFF, 4'h5, 1'b1);

      run_req("R6 unicast agent 0", 8'd0, 1'b0, 0, 0, 1'b0, 32'h0, 32'h0);
      run_req("R6 unicast agent 200", 8'd200, 1'b0, 0, 0, 1'b0, 32'h0, 32'h0);
      run_req("R6 duplicate ID lowest wins", 8'd7, 1'b0, 0, 0, 1'b0, 32'h0, 32'h0);
      run_req("R6 R10 no match absent agent", 8'd9, 1'b0, 0, 0, 1'b0, 32'h0, 32'h0);
      run_req("R5 broadcast", 8'hFF, 1'b0, 0, 0, 1'b0, 32'h0, 32'h0);
      run_req("R4 self", 8'd0, 1'b0, 1, 3, 1'b0, 32'h0, 32'h0);
      run_req("R4 R10 self absent", 8'd0, 1'b0, 1, 9, 1'b0, 32'h0, 32'h0);
      run_req("R2 all incl self", 8'd0, 1'b0, 2, 3, 1'b0, 32'h0, 32'h0);
      run_req("R3 all but self", 8'd0, 1'b0, 3, 3, 1'b0, 32'h0, 32'h0);
      run_req("R7 flat", 8'h01, 1'b1, 0, 0, 1'b0, 32'h0, 32'h0);
      run_req("R8 cluster match", 8'h53, 1'b1, 0, 0, 1'b0, 32'h0, 32'h0);
      run_req("R8 cluster other group", 8'h42, 1'b1, 0, 0, 1'b0, 32'h0, 32'h0);
      run_req("R9 undefined model", 8'hFF, 1'b1, 0, 0, 1'b0, 32'h0, 32'h0);
      run_req("R11 lowpri all", 8'd0, 1'b0, 2, 0, 1'b1, 32'h0, 32'h0);
      run_req("R11 lowpri logical", 8'h80, 1'b1, 0, 0, 1'b1, 32'h0, 32'h0);
      run_req("R11 lowpri empty", 8'd9, 1'b0, 0, 0, 1'b1, 32'h0, 32'h0);
      run_req("R13 stray bits set", 8'd100, 1'b0, 0, 0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

      // random table with duplicate IDs and mixed models
      for (int i = 0; i < N; i++) begin
         int r;
         logic [3:0] mdl;
         r = $urandom % 8;
         if (r < 3) mdl = 4'h0;
         else if (r < 6) mdl = 4'hF;
         else mdl = 4'(1 + ($urandom % 14));
         wr(i, 8'($urandom % 64), 8'($urandom), mdl, ($urandom % 5) != 0);
      end
      for (int n = 0; n < 120; n++) begin
         sh = ($urandom % 3 == 0) ? int'($urandom % 4) : 0;
         lg = $urandom % 2;
         d  = ($urandom % 6 == 0) ? 8'hFF : 8'($urandom % 80);
         run_req("R13 random R2 R3 R7 R8 R9 R10", d, lg, sh, int'($urandom % N),
                 bit'($urandom % 4 == 0), $urandom, $urandom);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule